// File: doc/BRIEF.md
# Positional Index Table

This block keeps a small, register-based table of RAM addresses so that an external data RAM can be treated as an ordered list. Each slot of the table holds the RAM address of the list element at that position. An element can be inserted or removed at any position in one clock cycle. The payload words in the RAM never move. Only the short address indexes shift inside the table. Each slot also carries a small tag that moves with its index.

The caller applies an operation and a slot number. On an insert, the block presents the RAM address that is free for the new element, and the caller writes the payload there in the same cycle. On a delete, the block presents the address being released. On any cycle, it presents the address held at the requested slot, which is used for plain reads. The free address on an insert is the one held in the top slot. It wraps down into the target position. On a delete, the released address wraps up into the top slot, so the table always holds a permutation of every RAM address. A length counter with full and empty flags supports queue-like or stack-like use.

The slot count must be a power of two.

Top module: `slot_remap_table`

## Requirements
- R1: After reset, slot k holds index k, every tag is zero, length is 0, `empty` is 1 and `full` is 0.
- R2: With `op_code` 2'b01 (insert) and the table not full, `ins_addr` shows the index in slot SLOTS-1 during that cycle. On the clock edge that index moves into slot `op_slot`, and every entry from `op_slot` up to SLOTS-2 moves one slot higher.
- R3: With `op_code` 2'b10 (delete), `del_addr` shows the index in slot `op_slot` during that cycle. On the clock edge that index moves into slot SLOTS-1, and every entry above `op_slot` moves one slot lower.
- R4: `acc_addr` and `acc_tag` show, combinationally, the index and tag held in slot `op_slot`. With `op_code` 2'b00 or 2'b11 (no operation), the table and length are left unchanged apart from tag writes.
- R5: An insert that is applied while not full raises length by one. An insert that is applied while full changes neither the table nor the length.
- R6: A delete lowers length by one only when `op_slot` is less than length. Otherwise length is unchanged, but the entries still rotate as in R3.
- R7: `full` is 1 exactly when length equals SLOTS, and `empty` is 1 exactly when length is 0.
- R8: Each tag moves together with its index whenever entries shift.
- R9: When `ins_tag_en` is set, the entry placed at the insert position takes `ins_tag`. When `del_tag_en` is set, the entry that wraps into the top slot on a delete takes `del_tag`. When an enable is clear, the entry keeps its own tag.
- R10: When `twr_en` is set on a cycle with no operation, the tag of slot `twr_slot` becomes `twr_data`. On an insert or delete cycle, the tag write is ignored.
- R11: The indexes in the table always form a permutation of 0 to SLOTS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 2 | 00 none, 01 insert, 10 delete, 11 none |
| op_slot | input | IDX_W | Target slot of the operation or access |
| ins_tag_en | input | 1 | Apply `ins_tag` on insert |
| ins_tag | input | TAG_W | Tag for the inserted entry |
| del_tag_en | input | 1 | Apply `del_tag` on delete |
| del_tag | input | TAG_W | Tag for the evicted entry |
| twr_en | input | 1 | Tag write request |
| twr_slot | input | IDX_W | Slot whose tag is written |
| twr_data | input | TAG_W | Tag value to write |
| ins_addr | output | IDX_W | RAM address to write on insert |
| del_addr | output | IDX_W | RAM address released on delete |
| acc_addr | output | IDX_W | RAM address held at `op_slot` |
| acc_tag | output | TAG_W | Tag held at `op_slot` |
| all_idx | output | SLOTS*IDX_W | All indexes, slot k at bits k*IDX_W |
| all_tag | output | SLOTS*TAG_W | All tags, slot k at bits k*TAG_W |
| length | output | $clog2(SLOTS+1) | Number of live entries |
| full | output | 1 | Length equals SLOTS |
| empty | output | 1 | Length is zero |

## Verification
The hardest situations to reach are edge cases at the limits of the table. One is an insert that arrives while the table is full. Another is a delete aimed at or beyond the current length, which rotates the table without shrinking the list. A third is a tag write that coincides with a shift. Directed steps fill the table to its limit and then apply each of these cases. A long random run follows, with inserts and deletes weighted evenly. Over many cycles this drives the length up and down between empty and full. Throughout the run, the bench compares the table against a list model, and it reads payloads back through a modelled RAM.

// File: rtl/slot_remap_pkg.sv
package slot_remap_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_INS  = 2'b01,
        OP_DEL  = 2'b10,
        OP_RSV  = 2'b11
    } op_e;

    typedef struct packed {
        logic ins;
        logic del;
        logic idle;
    } op_dec_t;

    // An insert into a full table is dropped; the reserved code acts as none.
    function automatic op_dec_t decode_op(input logic [1:0] code, input logic is_full);
        op_dec_t d;
        d.ins  = (op_e'(code) == OP_INS) && !is_full;
        d.del  = (op_e'(code) == OP_DEL);
        d.idle = (op_e'(code) == OP_NONE) || (op_e'(code) == OP_RSV);
        return d;
    endfunction

endpackage

// File: rtl/slot_remap_cell.sv
module slot_remap_cell
    import slot_remap_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 4,
    parameter int POS   = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  op_dec_t          dec,
    input  logic [IDX_W-1:0] slot,
    input  logic [IDX_W-1:0] below_idx,
    input  logic [TAG_W-1:0] below_tag,
    input  logic [IDX_W-1:0] above_idx,
    input  logic [TAG_W-1:0] above_tag,
    input  logic [IDX_W-1:0] ins_wrap_idx,
    input  logic [TAG_W-1:0] ins_wrap_tag,
    input  logic [IDX_W-1:0] del_wrap_idx,
    input  logic [TAG_W-1:0] del_wrap_tag,
    input  logic             twr_en,
    input  logic [IDX_W-1:0] twr_slot,
    input  logic [TAG_W-1:0] twr_data,
    output logic [IDX_W-1:0] cur_idx,
    output logic [TAG_W-1:0] cur_tag
);
    localparam logic [IDX_W-1:0] MY  = IDX_W'(POS);
    localparam logic             TOP = (POS == SLOTS - 1);

    logic [IDX_W-1:0] nxt_idx;
    logic [TAG_W-1:0] nxt_tag;

    always_comb begin
        nxt_idx = cur_idx;
        nxt_tag = cur_tag;
        if (dec.ins) begin
            if (MY == slot) begin
                nxt_idx = ins_wrap_idx;
                nxt_tag = ins_wrap_tag;
            end else if (MY > slot) begin
                nxt_idx = below_idx;
                nxt_tag = below_tag;
            end
        end else if (dec.del) begin
            if (TOP) begin
                nxt_idx = del_wrap_idx;
                nxt_tag = del_wrap_tag;
            end else if (MY >= slot) begin
                nxt_idx = above_idx;
                nxt_tag = above_tag;
            end
        end else if (dec.idle && twr_en && (twr_slot == MY)) begin
            nxt_tag = twr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx <= MY;
            cur_tag <= '0;
        end else begin
            cur_idx <= nxt_idx;
            cur_tag <= nxt_tag;
        end
    end
endmodule

// File: rtl/slot_remap_len.sv
module slot_remap_len #(
    parameter int SLOTS = 8,
    parameter int IDX_W = 3,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grow,
    input  logic             shrink_req,
    input  logic [IDX_W-1:0] slot,
    output logic [LEN_W-1:0] length,
    output logic             full,
    output logic             empty
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(SLOTS);

    logic shrink;
    assign shrink = shrink_req && (LEN_W'(slot) < length);

    always_ff @(posedge clk) begin
        if (rst) begin
            length <= '0;
        end else if (grow) begin
            length <= length + LEN_W'(1);
        end else if (shrink) begin
            length <= length - LEN_W'(1);
        end
    end

    assign full  = (length == CAP);
    assign empty = (length == '0);
endmodule

// File: rtl/slot_remap_table.sv
module slot_remap_table
    import slot_remap_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int IDX_W = $clog2(SLOTS),
    parameter int TAG_W = 4,
    parameter int LEN_W = $clog2(SLOTS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [1:0]             op_code,
    input  logic [IDX_W-1:0]       op_slot,
    input  logic                   ins_tag_en,
    input  logic [TAG_W-1:0]       ins_tag,
    input  logic                   del_tag_en,
    input  logic [TAG_W-1:0]       del_tag,
    input  logic                   twr_en,
    input  logic [IDX_W-1:0]       twr_slot,
    input  logic [TAG_W-1:0]       twr_data,
    output logic [IDX_W-1:0]       ins_addr,
    output logic [IDX_W-1:0]       del_addr,
    output logic [IDX_W-1:0]       acc_addr,
    output logic [TAG_W-1:0]       acc_tag,
    output logic [SLOTS*IDX_W-1:0] all_idx,
    output logic [SLOTS*TAG_W-1:0] all_tag,
    output logic [LEN_W-1:0]       length,
    output logic                   full,
    output logic                   empty
);
    localparam int LAST = SLOTS - 1;

    logic [IDX_W-1:0] idx_q [SLOTS];
    logic [TAG_W-1:0] tag_q [SLOTS];
    op_dec_t          dec;
    logic [TAG_W-1:0] ins_wrap_tag;
    logic [TAG_W-1:0] del_wrap_tag;

    assign dec = decode_op(op_code, full);

    assign ins_addr     = idx_q[LAST];
    assign del_addr     = idx_q[op_slot];
    assign acc_addr     = idx_q[op_slot];
    assign acc_tag      = tag_q[op_slot];
    assign ins_wrap_tag = ins_tag_en ? ins_tag : tag_q[LAST];
    assign del_wrap_tag = del_tag_en ? del_tag : tag_q[op_slot];

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        localparam int LO = (k == 0)    ? k : k - 1;
        localparam int HI = (k == LAST) ? k : k + 1;

        slot_remap_cell #(
            .SLOTS(SLOTS), .IDX_W(IDX_W), .TAG_W(TAG_W), .POS(k)
        ) u_cell (
            .clk         (clk),
            .rst         (rst),
            .dec         (dec),
            .slot        (op_slot),
            .below_idx   (idx_q[LO]),
            .below_tag   (tag_q[LO]),
            .above_idx   (idx_q[HI]),
            .above_tag   (tag_q[HI]),
            .ins_wrap_idx(idx_q[LAST]),
            .ins_wrap_tag(ins_wrap_tag),
            .del_wrap_idx(idx_q[op_slot]),
            .del_wrap_tag(del_wrap_tag),
            .twr_en      (twr_en),
            .twr_slot    (twr_slot),
            .twr_data    (twr_data),
            .cur_idx     (idx_q[k]),
            .cur_tag     (tag_q[k])
        );

        assign all_idx[k*IDX_W +: IDX_W] = idx_q[k];
        assign all_tag[k*TAG_W +: TAG_W] = tag_q[k];
    end

    slot_remap_len #(
        .SLOTS(SLOTS), .IDX_W(IDX_W), .LEN_W(LEN_W)
    ) u_len (
        .clk       (clk),
        .rst       (rst),
        .grow      (dec.ins),
        .shrink_req(dec.del),
        .slot      (op_slot),
        .length    (length),
        .full      (full),
        .empty     (empty)
    );
endmodule

// File: rtl/slot_remap_chk.sv
module slot_remap_chk #(
    parameter int SLOTS = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 4,
    parameter int LEN_W = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [1:0]             op_code,
    input logic [IDX_W-1:0]       op_slot,
    input logic [IDX_W-1:0]       ins_addr,
    input logic [IDX_W-1:0]       del_addr,
    input logic [SLOTS*IDX_W-1:0] all_idx,
    input logic [LEN_W-1:0]       length,
    input logic                   full
);
    localparam int LAST_LSB = (SLOTS - 1) * IDX_W;

    function automatic logic is_perm(input logic [SLOTS*IDX_W-1:0] v);
        logic [SLOTS-1:0] seen;
        seen = '0;
        for (int k = 0; k < SLOTS; k++) seen[v[k*IDX_W +: IDX_W]] = 1'b1;
        return &seen;
    endfunction

    // R11
    perm_kept_chk: assert property (@(posedge clk) disable iff (rst)
        is_perm(all_idx));

    // R2
    ins_place_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == 2'b01 && !full) |=>
            all_idx[$past(op_slot)*IDX_W +: IDX_W] == $past(ins_addr));

    // R3
    del_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == 2'b10) |=> all_idx[LAST_LSB +: IDX_W] == $past(del_addr));

    // R5
    ins_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == 2'b01 && !full) |=> length == $past(length) + LEN_W'(1));

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == 2'b01 && full) |=> $stable(length) && $stable(all_idx));

    // R6
    del_far_chk: assert property (@(posedge clk) disable iff (rst)
        (op_code == 2'b10 && LEN_W'(op_slot) >= length) |=> $stable(length));

    // R7
    len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        length <= LEN_W'(SLOTS));
endmodule

bind slot_remap_table slot_remap_chk #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/slot_remap_table_test.sv
`timescale 1ns/1ps
module slot_remap_table_test;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam int TW = 4;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    op_code;
    logic [IW-1:0] op_slot;
    logic          ins_tag_en, del_tag_en, twr_en;
    logic [TW-1:0] ins_tag, del_tag, twr_data;
    logic [IW-1:0] twr_slot;
    logic [IW-1:0] ins_addr, del_addr, acc_addr;
    logic [TW-1:0] acc_tag;
    logic [N*IW-1:0] all_idx;
    logic [N*TW-1:0] all_tag;
    logic [LW-1:0] length;
    logic          full, empty;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    int m_idx [N];
    int m_tag [N];
    int m_val [N];
    int m_len;
    int ram   [N];

    always #10 clk = ~clk;

    slot_remap_table #(.SLOTS(N), .TAG_W(TW)) uut (.*);

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string ri, input string rt);
        for (int k = 0; k < N; k++) begin
            check(ri, $sformatf("index slot %0d", k), int'(all_idx[k*IW +: IW]), m_idx[k]);
            check(rt, $sformatf("tag slot %0d", k), int'(all_tag[k*TW +: TW]), m_tag[k]);
        end
        check("R5", "length", int'(length), m_len);
        check("R7", "full", int'(full), int'(m_len == N));
        check("R7", "empty", int'(empty), int'(m_len == 0));
    endtask

    task automatic apply(input logic [1:0] op, input int s,
                         input bit ie, input int it, input bit de, input int dt,
                         input bit we, input int ws, input int wd);
        int tmp_i, tmp_t, tmp_v, pay;
        string ri, rt;
        @(negedge clk);
        op_code = op; op_slot = IW'(s);
        ins_tag_en = ie; ins_tag = TW'(it);
        del_tag_en = de; del_tag = TW'(dt);
        twr_en = we; twr_slot = IW'(ws); twr_data = TW'(wd);
        #2;
        check("R4", "acc_addr", int'(acc_addr), m_idx[s]);
        check("R4", "acc_tag", int'(acc_tag), m_tag[s]);
        ri = "R4"; rt = "R8";
        if (op == 2'b01) begin
            ri = "R2";
            if (ie) rt = "R9";
            if (we) rt = "R10";
            if (m_len < N) begin
                check("R2", "ins_addr", int'(ins_addr), m_idx[N-1]);
                pay = int'($urandom % 65536);
                ram[ins_addr] = pay;
                tmp_i = m_idx[N-1];
                tmp_t = ie ? it : m_tag[N-1];
                for (int k = N - 1; k > s; k--) begin
                    m_idx[k] = m_idx[k-1];
                    m_tag[k] = m_tag[k-1];
                    m_val[k] = m_val[k-1];
                end
                m_idx[s] = tmp_i; m_tag[s] = tmp_t; m_val[s] = pay;
                m_len++;
            end else begin
                ri = "R5";
            end
        end else if (op == 2'b10) begin
            ri = (s >= m_len) ? "R6" : "R3";
            if (de) rt = "R9";
            if (we) rt = "R10";
            check("R3", "del_addr", int'(del_addr), m_idx[s]);
            tmp_i = m_idx[s];
            tmp_t = de ? dt : m_tag[s];
            tmp_v = m_val[s];
            for (int k = s; k < N - 1; k++) begin
                m_idx[k] = m_idx[k+1];
                m_tag[k] = m_tag[k+1];
                m_val[k] = m_val[k+1];
            end
            m_idx[N-1] = tmp_i; m_tag[N-1] = tmp_t; m_val[N-1] = tmp_v;
            if (s < m_len) m_len--;
        end else begin
            if (s < m_len) check("R4", "ram read", ram[acc_addr], m_val[s]);
            if (we) begin
                m_tag[ws] = wd;
                rt = "R10";
            end
        end
        @(posedge clk);
        #2;
        check_state(ri, rt);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; op_code = 2'b00; op_slot = '0;
        ins_tag_en = 0; ins_tag = '0; del_tag_en = 0; del_tag = '0;
        twr_en = 0; twr_slot = '0; twr_data = '0;
        for (int k = 0; k < N; k++) begin
            m_idx[k] = k; m_tag[k] = 0; m_val[k] = 0; ram[k] = 0;
        end
        m_len = 0;
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check_state("R1", "R1");
        @(negedge clk);
        rst = 1'b0;

        // R10 tag write on idle cycle, then ignored during insert
        apply(2'b00, 0, 0, 0, 0, 0, 1, 2, 5);
        apply(2'b01, 0, 1, 9, 0, 0, 0, 0, 0);
        apply(2'b01, 1, 0, 0, 0, 0, 1, 4, 7);
        apply(2'b11, 1, 0, 0, 0, 0, 1, 6, 3);
        // fill to full, then insert while full (R5)
        for (int k = 0; k < N; k++) apply(2'b01, k % 3, 0, 0, 0, 0, 0, 0, 0);
        apply(2'b01, 3, 1, 1, 0, 0, 0, 0, 0);
        // deletes: top slot with override (R9), then beyond length (R6)
        apply(2'b10, N - 1, 0, 0, 1, 12, 0, 0, 0);
        apply(2'b10, N - 1, 0, 0, 0, 0, 1, 0, 2);
        apply(2'b10, 0, 0, 0, 0, 0, 0, 0, 0);

        for (int i = 0; i < 800; i++) begin
            int r;
            r = int'($urandom % 8);
            apply(r < 3 ? 2'b01 : (r < 6 ? 2'b10 : (r == 6 ? 2'b00 : 2'b11)),
                  int'($urandom % N),
                  bit'($urandom % 2), int'($urandom % 16),
                  bit'($urandom % 2), int'($urandom % 16),
                  bit'($urandom % 2), int'($urandom % N), int'($urandom % 16));
        end
        // drain to empty, then delete on empty (R6)
        for (int k = 0; k < N; k++) apply(2'b10, 0, 0, 0, 0, 0, 0, 0, 0);
        apply(2'b10, 0, 0, 0, 0, 0, 0, 0, 0);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule